// File: doc/BRIEF.md
# MPLS Label Stack Update Engine

This block keeps a small hardware stack of 32-bit MPLS label entries for the packet now being forwarded, and changes that stack one command at a time. A command either pushes an entry taken straight from the command data, or updates the stack. An update looks up the top label in the label information base, swaps it for the label that comes back, and decrements its TTL. If the lookup misses, the TTL has run out, or there is no entry to update, the packet is dropped and the stack is cleared.

A supervisory state machine accepts one command at a time. It hands the work to either the information-base search controller or the stack controller, and never to both at once. It waits for the active controller to finish before it accepts the next command. The lookup uses a request/grant handshake to an external search unit. Each command ends with a one-cycle `done` pulse. `discard` and `overflow` pulse in the same cycle as `done` when they apply. The current depth and top entry are always visible.

Top module: `lse_update_engine`

## Requirements
- R1: An entry is packed as label in bits 31:12, class in bits 11:9, bottom-of-stack flag in bit 8 and TTL in bits 7:0. `top_entry` shows the top (level n) entry and reads zero when the stack is empty.
- R2: A push command (`cmd_upd`=0) stores `cmd_data` on top and raises the depth by one. The stored bottom flag is 1 exactly when the stack was empty before the push, whatever bit 8 of `cmd_data` holds. The depth changes only in a cycle where `done` is high.
- R3: A push into a full stack (`NENT` entries, 8 by default) leaves the depth and the top entry unchanged, and pulses `overflow` together with `done`.
- R4: An update (`cmd_upd`=1) on a non-empty stack raises `srch_req` with `srch_key` equal to the top label. Both stay steady until `srch_gnt` is seen. `srch_hit` and `srch_label` are sampled in the grant cycle.
- R5: On a hit with a top TTL above 1, the top entry is replaced by the returned label with the old class and bottom flag and the TTL minus one. The depth is unchanged and `discard` stays low.
- R6: On a lookup miss the stack is cleared to depth 0, and `discard` pulses in the same cycle as `done`.
- R7: On a hit where the top TTL is 0 or 1, the packet is discarded exactly as in R6.
- R8: An update on an empty stack is discarded as in R6 without raising `srch_req`.
- R9: `cmd_ready` is low from the cycle after a command is accepted until `done`. Commands offered while busy are ignored. The stack and search controllers are never enabled in the same cycle.
- R10: After reset the depth is 0, `top_entry` is 0, `cmd_ready` is high, and `done`, `discard`, `overflow` and `srch_req` are low. `done` never stays high for two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_upd | input | 1 | 0 = push `cmd_data`, 1 = update through lookup |
| cmd_data | input | 32 | Entry to push |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| srch_req | output | 1 | Lookup request to the information base |
| srch_key | output | 20 | Label being looked up |
| srch_gnt | input | 1 | Lookup finished this cycle |
| srch_hit | input | 1 | Lookup found an entry (valid with grant) |
| srch_label | input | 20 | Replacement label (valid with grant) |
| done | output | 1 | One-cycle end-of-command pulse |
| discard | output | 1 | Packet dropped, stack cleared (with done) |
| overflow | output | 1 | Push refused, stack full (with done) |
| depth | output | DEPTH_W (4) | Number of entries held |
| top_entry | output | 32 | Current top entry, zero when empty |

## Verification
The bound checker checks every cycle that the two controllers are never enabled together. It also checks that `discard` and `overflow` only appear with `done` and leave the expected depth, that `done` is a single pulse, that the depth never moves outside a `done` cycle or beyond `NENT`, and that a pending request keeps its key. Only the bench's scenarios can show the data results. These are the bottom-flag rule on push, the swapped label with the kept class bits and the decremented TTL, the TTL-0 and TTL-1 discards, the missing request on an empty update, and a command offered mid-lookup being dropped.

// File: rtl/lse_pkg.sv
// Shared types for the label stack update engine.
// Assumes the 32-bit entry layout: label, class, bottom flag, TTL (MSB first).
package lse_pkg;
    typedef struct packed {
        logic [19:0] label;
        logic [2:0]  tc;
        logic        bos;
        logic [7:0]  ttl;
    } lse_t;

    // operations the supervisor hands to the stack controller
    typedef enum logic [1:0] {SC_PUSH, SC_APPLY, SC_DROP} sc_op_e;
    // operations the stack controller issues to the storage
    typedef enum logic [1:0] {ST_NONE, ST_PUSH, ST_REPL, ST_CLR} st_op_e;
    // supervisor states
    typedef enum logic [1:0] {SV_IDLE, SV_LIB, SV_STK} sv_state_e;
    // search controller states
    typedef enum logic [1:0] {LB_IDLE, LB_REQ, LB_DONE} lib_state_e;
endpackage

// File: rtl/lse_stack_store.sv
// Storage for the label stack: NENT slots plus a depth counter.
// Assumes the caller never asks for a push when full or a replace when empty;
// a push at full is still blocked here as a second guard.
module lse_stack_store
    import lse_pkg::*;
#(
    parameter int NENT    = 8,
    parameter int DEPTH_W = $clog2(NENT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  st_op_e             op,
    input  lse_t               wdata,
    output logic [DEPTH_W-1:0] depth,
    output lse_t               top
);
    localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(NENT);

    logic [DEPTH_W-1:0] cnt;
    lse_t [NENT-1:0]    slot_v;

    // depth counter: grows on push, clears on discard
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case (op)
                ST_PUSH: if (cnt != FULL) cnt <= cnt + 1'b1;
                ST_CLR:  cnt <= '0;
                default: cnt <= cnt;
            endcase
        end
    end

    // one register per level; level g+1 is written by a push at depth g
    // or by a replace when it is the top
    for (genvar g = 0; g < NENT; g++) begin : g_slot
        lse_t q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if ((op == ST_PUSH && cnt == DEPTH_W'(g)) ||
                     (op == ST_REPL && cnt == DEPTH_W'(g + 1)))
                q <= wdata;
        end
        assign slot_v[g] = q;
    end

    // top-of-stack read mux, zero when empty
    always_comb begin
        top = '0;
        for (int i = 0; i < NENT; i++)
            if (cnt == DEPTH_W'(i + 1)) top = slot_v[i];
    end

    assign depth = cnt;
endmodule

// File: rtl/lse_lib_ctrl.sv
// Information-base search controller: while enabled, raises a request with
// the key, waits for the grant, latches hit and label, then signals done.
// Assumes the supervisor drops en in the cycle done is seen.
module lse_lib_ctrl
    import lse_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [19:0] key,
    output logic        srch_req,
    output logic [19:0] srch_key,
    input  logic        srch_gnt,
    input  logic        srch_hit,
    input  logic [19:0] srch_label,
    output logic        lib_done,
    output logic        res_hit,
    output logic [19:0] res_label
);
    lib_state_e st;

    // request/grant sequencing and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= LB_IDLE;
            res_hit   <= 1'b0;
            res_label <= '0;
        end else begin
            case (st)
                LB_IDLE: if (en) st <= LB_REQ;
                LB_REQ: if (srch_gnt) begin
                    res_hit   <= srch_hit;
                    res_label <= srch_label;
                    st        <= LB_DONE;
                end
                default: st <= LB_IDLE;
            endcase
        end
    end

    assign srch_req = (st == LB_REQ);
    assign srch_key = key;
    assign lib_done = (st == LB_DONE);
endmodule

// File: rtl/lse_stack_ctrl.sv
// Stack controller: turns a supervisor operation into one storage operation
// in the cycle it is enabled, and reports discard/overflow for that cycle.
// Assumes hold is the top entry captured when the command was accepted.
module lse_stack_ctrl
    import lse_pkg::*;
#(
    parameter int NENT    = 8,
    parameter int DEPTH_W = $clog2(NENT + 1)
) (
    input  logic               en,
    input  sc_op_e             op,
    input  lse_t               ext,
    input  lse_t               hold,
    input  logic               hit,
    input  logic [19:0]        new_label,
    input  logic [DEPTH_W-1:0] depth,
    output st_op_e             st_op,
    output lse_t               wdata,
    output logic               discard,
    output logic               overflow
);
    // choose storage action and the entry to write
    always_comb begin
        st_op    = ST_NONE;
        wdata    = '0;
        discard  = 1'b0;
        overflow = 1'b0;
        if (en) begin
            case (op)
                SC_PUSH: begin
                    if (depth == DEPTH_W'(NENT)) begin
                        overflow = 1'b1;
                    end else begin
                        st_op = ST_PUSH;
                        wdata = '{label: ext.label, tc: ext.tc,
                                  bos: (depth == '0), ttl: ext.ttl};
                    end
                end
                SC_APPLY: begin
                    if (!hit || hold.ttl <= 8'd1) begin
                        discard = 1'b1;
                        st_op   = ST_CLR;
                    end else begin
                        st_op = ST_REPL;
                        wdata = '{label: new_label, tc: hold.tc,
                                  bos: hold.bos, ttl: hold.ttl - 8'd1};
                    end
                end
                default: begin
                    discard = 1'b1;
                    st_op   = ST_CLR;
                end
            endcase
        end
    end
endmodule

// File: rtl/lse_update_engine.sv
// Label stack update engine top: a supervisor takes one command at a time,
// enables either the search controller or the stack controller, and waits
// for it to finish before going idle again.
// Assumes srch_gnt eventually answers every srch_req.
module lse_update_engine
    import lse_pkg::*;
#(
    parameter int NENT    = 8,
    parameter int DEPTH_W = $clog2(NENT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_upd,
    input  logic [31:0]        cmd_data,
    output logic               cmd_ready,
    output logic               srch_req,
    output logic [19:0]        srch_key,
    input  logic               srch_gnt,
    input  logic               srch_hit,
    input  logic [19:0]        srch_label,
    output logic               done,
    output logic               discard,
    output logic               overflow,
    output logic [DEPTH_W-1:0] depth,
    output logic [31:0]        top_entry
);
    sv_state_e state;
    sc_op_e    sc_op_q;
    lse_t      hold_ext, hold_top, top;
    logic      stk_en, lib_en, lib_done, res_hit;
    logic      sc_discard, sc_overflow;
    logic      done_q, disc_q, ovf_q;
    logic [19:0] res_label;
    st_op_e    st_op;
    lse_t      st_wdata;

    assign stk_en = (state == SV_STK);
    assign lib_en = (state == SV_LIB);

    // supervisor: accept, dispatch to one controller, report completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SV_IDLE;
            sc_op_q  <= SC_PUSH;
            hold_ext <= '0;
            hold_top <= '0;
            done_q   <= 1'b0;
            disc_q   <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            disc_q <= 1'b0;
            ovf_q  <= 1'b0;
            case (state)
                SV_IDLE: if (cmd_valid) begin
                    hold_ext <= lse_t'(cmd_data);
                    hold_top <= top;
                    if (!cmd_upd) begin
                        sc_op_q <= SC_PUSH;
                        state   <= SV_STK;
                    end else if (depth == '0) begin
                        sc_op_q <= SC_DROP;
                        state   <= SV_STK;
                    end else begin
                        state   <= SV_LIB;
                    end
                end
                SV_LIB: if (lib_done) begin
                    sc_op_q <= SC_APPLY;
                    state   <= SV_STK;
                end
                default: begin
                    done_q <= 1'b1;
                    disc_q <= sc_discard;
                    ovf_q  <= sc_overflow;
                    state  <= SV_IDLE;
                end
            endcase
        end
    end

    lse_lib_ctrl u_lib (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (lib_en),
        .key        (hold_top.label),
        .srch_req   (srch_req),
        .srch_key   (srch_key),
        .srch_gnt   (srch_gnt),
        .srch_hit   (srch_hit),
        .srch_label (srch_label),
        .lib_done   (lib_done),
        .res_hit    (res_hit),
        .res_label  (res_label)
    );

    lse_stack_ctrl #(.NENT(NENT), .DEPTH_W(DEPTH_W)) u_stk (
        .en        (stk_en),
        .op        (sc_op_q),
        .ext       (hold_ext),
        .hold      (hold_top),
        .hit       (res_hit),
        .new_label (res_label),
        .depth     (depth),
        .st_op     (st_op),
        .wdata     (st_wdata),
        .discard   (sc_discard),
        .overflow  (sc_overflow)
    );

    lse_stack_store #(.NENT(NENT), .DEPTH_W(DEPTH_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (st_op),
        .wdata (st_wdata),
        .depth (depth),
        .top   (top)
    );

    assign cmd_ready = (state == SV_IDLE);
    assign done      = done_q;
    assign discard   = disc_q;
    assign overflow  = ovf_q;
    assign top_entry = top;
endmodule

// File: rtl/lse_update_chk.sv
// Protocol and state checker for lse_update_engine, attached by bind.
// Assumes reset is held for at least one clock edge at start-up.
module lse_update_chk #(
    parameter int NENT    = 8,
    parameter int DEPTH_W = $clog2(NENT + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               srch_req,
    input logic               srch_gnt,
    input logic [19:0]        srch_key,
    input logic               done,
    input logic               discard,
    input logic               overflow,
    input logic [DEPTH_W-1:0] depth,
    input logic               stk_en,
    input logic               lib_en
);
    // R9
    excl_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_en && lib_en));

    // R6
    discard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discard |-> (done && depth == '0));

    // R3
    overflow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (done && depth == DEPTH_W'(NENT)));

    // R3
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DEPTH_W'(NENT));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    depth_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(depth) |-> done);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_req && !srch_gnt) |=> (srch_req && $stable(srch_key)));
endmodule

bind lse_update_engine lse_update_chk #(.NENT(NENT), .DEPTH_W(DEPTH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .srch_req (srch_req),
    .srch_gnt (srch_gnt),
    .srch_key (srch_key),
    .done     (done),
    .discard  (discard),
    .overflow (overflow),
    .depth    (depth),
    .stk_en   (stk_en),
    .lib_en   (lib_en)
);

// File: tb/lse_update_engine_tb_top.sv
// Bench for lse_update_engine: a vector table walked by one loop, then
// directed tests for reset, overflow and commands offered while busy.
module lse_update_engine_tb_top;
    localparam int NENT = 8;
    localparam int DW   = $clog2(NENT + 1);

    typedef struct packed {
        logic        upd;
        logic [31:0] data;
        logic        hit;
        logic [19:0] lab;
        logic [19:0] key;
        logic [3:0]  dep;
        logic [31:0] top;
        logic        disc;
    } vec_t;

    // entry hex = LLLLL E TT, E = {class, bottom flag}
    localparam vec_t VEC [10] = '{
        '{1'b0, 32'h00011A40, 1'b0, 20'h0,     20'h0,     4'd1, 32'h00011B40, 1'b0}, // R2 empty push sets bos
        '{1'b0, 32'h00022320, 1'b0, 20'h0,     20'h0,     4'd2, 32'h00022220, 1'b0}, // R2 bos cleared
        '{1'b1, 32'h0,        1'b1, 20'h00777, 20'h00022, 4'd2, 32'h0077721F, 1'b0}, // R5 swap
        '{1'b1, 32'h0,        1'b0, 20'h0,     20'h00777, 4'd0, 32'h00000000, 1'b1}, // R6 miss
        '{1'b0, 32'h00033002, 1'b0, 20'h0,     20'h0,     4'd1, 32'h00033102, 1'b0}, // R2
        '{1'b1, 32'h0,        1'b1, 20'h00044, 20'h00033, 4'd1, 32'h00044101, 1'b0}, // R5 ttl 2
        '{1'b1, 32'h0,        1'b1, 20'h00099, 20'h00044, 4'd0, 32'h00000000, 1'b1}, // R7 ttl 1
        '{1'b1, 32'h0,        1'b1, 20'h00099, 20'h0,     4'd0, 32'h00000000, 1'b1}, // R8 empty
        '{1'b0, 32'h00055E00, 1'b0, 20'h0,     20'h0,     4'd1, 32'h00055F00, 1'b0}, // R2
        '{1'b1, 32'h0,        1'b1, 20'h00066, 20'h00055, 4'd0, 32'h00000000, 1'b1}  // R7 ttl 0
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_upd = 1'b0;
    logic [31:0] cmd_data = '0;
    logic srch_gnt = 1'b0, srch_hit = 1'b0;
    logic [19:0] srch_label = '0;
    logic cmd_ready, srch_req, done, discard, overflow;
    logic [19:0] srch_key;
    logic [DW-1:0] depth;
    logic [31:0] top_entry;

    int tests = 0, fails = 0;
    logic got_done, got_disc, got_ovf, req_seen;
    logic [19:0] key_seen;

    always #2 clk = ~clk;

    lse_update_engine #(.NENT(NENT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_upd(cmd_upd),
        .cmd_data(cmd_data), .cmd_ready(cmd_ready), .srch_req(srch_req),
        .srch_key(srch_key), .srch_gnt(srch_gnt), .srch_hit(srch_hit),
        .srch_label(srch_label), .done(done), .discard(discard),
        .overflow(overflow), .depth(depth), .top_entry(top_entry)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // offer one command, answer any lookup after a delay, wait for done
    task automatic run_cmd(input logic upd, input logic [31:0] data,
                           input logic hit, input logic [19:0] lab,
                           input logic inj);
        logic granted;
        int waited;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_upd = upd; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        req_seen = 1'b0; granted = 1'b0; waited = 0;
        got_done = 1'b0; got_disc = 1'b0; got_ovf = 1'b0; key_seen = '0;
        for (int n = 0; n < 60 && !got_done; n++) begin
            if (done) begin
                got_done = 1'b1; got_disc = discard; got_ovf = overflow;
            end else if (srch_req && !granted) begin
                if (!req_seen) begin
                    req_seen = 1'b1; key_seen = srch_key;
                    if (inj) begin
                        cmd_valid = 1'b1; cmd_upd = 1'b0; cmd_data = 32'hFFFFF0FF;
                        chk("R9", "cmd_ready while busy", 32'(cmd_ready), 32'd0);
                    end
                end else begin
                    cmd_valid = 1'b0;
                    chk("R4", "key held", 32'(srch_key), 32'(key_seen));
                end
                waited++;
                if (waited == 3) begin
                    srch_gnt = 1'b1; srch_hit = hit; srch_label = lab; granted = 1'b1;
                end
            end else begin
                srch_gnt = 1'b0;
                cmd_valid = 1'b0;
            end
            if (!got_done) @(negedge clk);
        end
        srch_gnt = 1'b0;
        chk("R10", "done seen", 32'(got_done), 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "depth", 32'(depth), 32'd0);
        chk("R10", "top", top_entry, 32'h0);
        chk("R10", "ready", 32'(cmd_ready), 32'd1);
        chk("R10", "outputs", {28'd0, done, discard, overflow, srch_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk (R1 layout, R2, R4..R8)
        for (int v = 0; v < 10; v++) begin
            run_cmd(VEC[v].upd, VEC[v].data, VEC[v].hit, VEC[v].lab, 1'b0);
            chk("R1", "top entry", top_entry, VEC[v].top);
            chk("R2", "depth", 32'(depth), 32'(VEC[v].dep));
            chk("R6", "discard", 32'(got_disc), 32'(VEC[v].disc));
            chk("R3", "no overflow", 32'(got_ovf), 32'd0);
            if (VEC[v].upd) begin
                if (VEC[v].key == 20'h0) begin
                    chk("R8", "no request", 32'(req_seen), 32'd0);
                end else begin
                    chk("R4", "request", 32'(req_seen), 32'd1);
                    chk("R4", "key", 32'(key_seen), 32'(VEC[v].key));
                end
            end
        end

        // R3 fill, then push into full stack
        for (int i = 1; i <= NENT; i++)
            run_cmd(1'b0, {20'(i), 4'h2, 8'h10}, 1'b0, 20'h0, 1'b0);
        chk("R3", "depth full", 32'(depth), 32'(NENT));
        chk("R2", "top before overflow", top_entry, 32'h00008210);
        run_cmd(1'b0, 32'hABCDE111, 1'b0, 20'h0, 1'b0);
        chk("R3", "overflow pulse", 32'(got_ovf), 32'd1);
        chk("R3", "depth kept", 32'(depth), 32'(NENT));
        chk("R3", "top kept", top_entry, 32'h00008210);

        // R9 push offered mid-lookup is ignored; R5 swap at full depth
        run_cmd(1'b1, 32'h0, 1'b1, 20'h12345, 1'b1);
        chk("R9", "depth unchanged", 32'(depth), 32'(NENT));
        chk("R5", "swap at full", top_entry, 32'h1234520F);
        chk("R5", "no discard", 32'(got_disc), 32'd0);
        @(negedge clk);
        chk("R10", "done single pulse", 32'(done), 32'd0);
        chk("R9", "ready again", 32'(cmd_ready), 32'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule